// File: doc/BRIEF.md
# Gapped-Clock Frame Locator with Slot Demultiplexer

This block receives one channelized 32-slot link whose bit clock stops for roughly one bit period once per frame. A much faster system clock samples the link clock and the link data, times the low interval in front of every rising edge, and treats an interval longer than a programmable threshold as the frame marker. The bit that follows the marker is the most significant bit of slot 1. Slot 0 has no bits on this link because the clock gap takes its place.

After each byte of the link is assembled, the block looks up the byte's slot in a 32-entry map. Each entry holds a provision flag and a 7-bit channel number. A provisioned byte leaves the block as a one-cycle result carrying the channel, the byte and a flag for slot 1. An unprovisioned byte is dropped. The map is loaded indirectly. A channel word is staged first, and a select word then commits it to one slot of one link.

Top module: `gclk_slot_demux`

## Requirements
- R1: After reset and until the first frame marker, `out_valid` stays low, and no byte is produced.
- R2: A rising link-clock edge is a frame marker only when the number of system clocks counted since the previous rising edge, minus one, is strictly greater than `gap_thresh`. An equal count is an ordinary bit. A marker restarts assembly at bit 1 of slot 1.
- R3: Bits are assembled most significant bit first. The bit sampled at the first rising edge of a slot is bit 7 of `out_byte`.
- R4: A byte of a provisioned slot is presented on `out_byte` with that slot's channel on `out_chan`, for exactly one system clock with `out_valid` high. `out_first` is high with it when the slot is 1.
- R5: A byte of a slot whose provision flag is 0 produces no output.
- R6: Only slots 1 to 31 can be mapped. A select write naming slot 0 changes nothing. A byte that completes after slot 31 without an intervening marker counts as slot 0 and is dropped.
- R7: Several slots may carry the same channel number, and each of their bytes is forwarded with it.
- R8: A pulse on `cfg_data_wr` stages `{cfg_prov, cfg_chan}`. A pulse on `cfg_sel_wr` copies the staged word into entry `cfg_slot`, but only when `cfg_rwb` is 0 and `cfg_link` equals parameter `LINK_ID`. Any other select pulse leaves the map unchanged. The staged word stays in place for further select writes.
- R9: `out_valid` is never high on two consecutive system clocks.
- R10: A marker that arrives in the middle of a slot discards the partial byte. Bytes completed before the marker are still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_clk | input | 1 | Gapped link bit clock, asynchronous to `clk` |
| link_data | input | 1 | Link data, stable around rising `link_clk` |
| gap_thresh | input | 7 | Gap threshold in system-clock periods |
| cfg_data_wr | input | 1 | Stage the channel word |
| cfg_chan | input | 7 | Channel number to stage |
| cfg_prov | input | 1 | Provision flag to stage |
| cfg_sel_wr | input | 1 | Select word strobe |
| cfg_slot | input | 5 | Slot of the select word |
| cfg_link | input | 5 | Link number of the select word |
| cfg_rwb | input | 1 | 0 = write, 1 = read (no map change) |
| out_valid | output | 1 | One-cycle result strobe |
| out_chan | output | 7 | Channel of the forwarded byte |
| out_byte | output | 8 | Forwarded byte |
| out_first | output | 1 | Byte belongs to slot 1 |

## Verification
Whole frames with distinct, slot-dependent payloads are sent against a map that mixes shared channels, unprovisioned slots and ignored writes. This checks byte order, channel routing and dropping together. A frame that runs one byte past slot 31 separates correct slot wrapping from a block that maps slot 0. A frame cut short by an early marker shows that partial bytes are discarded. With the threshold raised, a single bit is stretched to exactly the threshold count while the real marker exceeds it. This shows that an equal interval does not realign the frame and that a strictly greater one does.

// File: rtl/gclk_demux_pkg.sv
package gclk_demux_pkg;
  localparam int unsigned CHAN_W = 7;
  localparam int unsigned SLOT_W = 5;
  localparam int unsigned LINK_W = 5;
  localparam int unsigned THR_W  = 7;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              prov;
    logic [CHAN_W-1:0] chan;
  } map_entry_t;
endpackage

// File: rtl/gclk_sampler.sv
module gclk_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_clk,
  input  logic link_data,
  output logic rise,
  output logic bit_val
);
  logic [STAGES:0]   ck_q, ck_d;
  logic [STAGES-1:0] dt_q, dt_d;

  genvar i;
  generate
    for (i = 0; i <= STAGES; i++) begin : g_ck
      if (i == 0) begin : g_in
        assign ck_d[i] = link_clk;
      end else begin : g_chain
        assign ck_d[i] = ck_q[i-1];
      end
    end
    for (i = 0; i < STAGES; i++) begin : g_dt
      if (i == 0) begin : g_in
        assign dt_d[i] = link_data;
      end else begin : g_chain
        assign dt_d[i] = dt_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      dt_q <= '0;
    end else begin
      ck_q <= ck_d;
      dt_q <= dt_d;
    end
  end

  assign rise    = ck_q[STAGES-1] & ~ck_q[STAGES];
  assign bit_val = dt_q[STAGES-1];

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R9
endmodule

// File: rtl/gclk_gap_timer.sv
module gclk_gap_timer #(
  parameter int unsigned THR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [THR_W-1:0] thresh,
  output logic             frame_mark
);
  localparam int unsigned CNT_W = THR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (rise)                  cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MAX;
    else        cnt_q <= cnt_d;
  end

  assign frame_mark = rise && (cnt_q > {1'b0, thresh});

  AST_CNT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/gclk_deframer.sv
module gclk_deframer #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              bit_val,
  input  logic              frame_mark,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic [SLOT_W-1:0] byte_slot
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BYTE_W - 1);
  localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);

  logic              aligned_q, aligned_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BYTE_W-2:0] sh_q, sh_d;

  assign byte_val  = {sh_q, bit_val};
  assign byte_slot = slot_q;
  assign byte_done = rise && aligned_q && !frame_mark && (idx_q == LAST_IDX);

  always_comb begin
    aligned_d = aligned_q;
    idx_d     = idx_q;
    slot_d    = slot_q;
    sh_d      = sh_q;
    if (frame_mark) begin
      aligned_d = 1'b1;
      idx_d     = IDX_W'(1);
      slot_d    = SLOT_ONE;
      sh_d      = {{(BYTE_W-2){1'b0}}, bit_val};
    end else if (rise && aligned_q) begin
      sh_d = {sh_q[BYTE_W-3:0], bit_val};
      if (idx_q == LAST_IDX) begin
        idx_d  = '0;
        slot_d = slot_q + 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      idx_q     <= '0;
      slot_q    <= '0;
      sh_q      <= '0;
    end else begin
      aligned_q <= aligned_d;
      idx_q     <= idx_d;
      slot_q    <= slot_d;
      sh_q      <= sh_d;
    end
  end

  AST_MARK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |=> (slot_q == SLOT_ONE && idx_q == IDX_W'(1))); // R10
  AST_SLOT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (slot_q == $past(slot_q) + 1'b1)); // R6
  AST_NO_BYTE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned_q |-> !byte_done); // R1
endmodule

// File: rtl/gclk_slot_map.sv
module gclk_slot_map
  import gclk_demux_pkg::*;
#(
  parameter int unsigned SLOT_W  = 5,
  parameter int unsigned LINK_W  = 5,
  parameter int unsigned LINK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  map_entry_t        data_in,
  input  logic              sel_wr,
  input  logic [SLOT_W-1:0] sel_slot,
  input  logic [LINK_W-1:0] sel_link,
  input  logic              sel_rwb,
  input  logic [SLOT_W-1:0] rd_slot,
  output map_entry_t        rd_entry
);
  localparam int unsigned NSLOT = 1 << SLOT_W;
  localparam logic [LINK_W-1:0] MY_LINK = LINK_W'(LINK_ID);

  map_entry_t stage_q, stage_d;
  map_entry_t [NSLOT-1:0] map_q;
  logic commit;

  assign commit = sel_wr && !sel_rwb && (sel_link == MY_LINK) && (sel_slot != '0);

  always_comb stage_d = data_wr ? data_in : stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_ent
      logic ent_en;
      assign ent_en = commit && (sel_slot == SLOT_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      map_q[g] <= '0;
        else if (ent_en) map_q[g] <= stage_q;
      end
    end
  endgenerate

  assign rd_entry = map_q[rd_slot];

  AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && sel_rwb) |=> $stable(map_q)); // R8
  AST_SLOT0_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !map_q[0].prov); // R6
endmodule

// File: rtl/gclk_slot_demux.sv
module gclk_slot_demux
  import gclk_demux_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LINK_ID     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_clk,
  input  logic              link_data,
  input  logic [THR_W-1:0]  gap_thresh,
  input  logic              cfg_data_wr,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic              cfg_prov,
  input  logic              cfg_sel_wr,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [LINK_W-1:0] cfg_link,
  input  logic              cfg_rwb,
  output logic              out_valid,
  output logic [CHAN_W-1:0] out_chan,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_first
);
  localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);

  logic [1:0] rst_sr;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_l = rst_sr[1];

  logic rise, bit_val, frame_mark, byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [SLOT_W-1:0] byte_slot;
  map_entry_t entry, stage_in;

  gclk_sampler #(.STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_l), .link_clk(link_clk), .link_data(link_data),
    .rise(rise), .bit_val(bit_val));

  gclk_gap_timer #(.THR_W(THR_W)) u_gap (
    .clk(clk), .rst_n(rst_l), .rise(rise), .thresh(gap_thresh),
    .frame_mark(frame_mark));

  gclk_deframer #(.SLOT_W(SLOT_W), .BYTE_W(BYTE_W)) u_dfr (
    .clk(clk), .rst_n(rst_l), .rise(rise), .bit_val(bit_val),
    .frame_mark(frame_mark), .byte_done(byte_done), .byte_val(byte_val),
    .byte_slot(byte_slot));

  assign stage_in.prov = cfg_prov;
  assign stage_in.chan = cfg_chan;

  gclk_slot_map #(.SLOT_W(SLOT_W), .LINK_W(LINK_W), .LINK_ID(LINK_ID)) u_map (
    .clk(clk), .rst_n(rst_l), .data_wr(cfg_data_wr), .data_in(stage_in),
    .sel_wr(cfg_sel_wr), .sel_slot(cfg_slot), .sel_link(cfg_link),
    .sel_rwb(cfg_rwb), .rd_slot(byte_slot), .rd_entry(entry));

  logic              vld_d, first_d, load_en;
  logic [CHAN_W-1:0] chan_d;
  logic [BYTE_W-1:0] byte_d;

  always_comb begin
    load_en = byte_done && entry.prov;
    vld_d   = load_en;
    first_d = load_en && (byte_slot == SLOT_ONE);
    chan_d  = load_en ? entry.chan : out_chan;
    byte_d  = load_en ? byte_val   : out_byte;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_chan  <= '0;
      out_byte  <= '0;
    end else begin
      out_valid <= vld_d;
      out_first <= first_d;
      out_chan  <= chan_d;
      out_byte  <= byte_d;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_l)
    out_valid |=> !out_valid); // R9
  AST_FIRST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_l)
    out_first |-> out_valid); // R4
  AST_OUT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_l)
    out_valid |-> $past(byte_done)); // R5
endmodule

// File: tb/gclk_slot_demux_test.sv
module gclk_slot_demux_test;
  localparam int CLK_PERIOD = 10;
  localparam int MY_LINK    = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       link_clk, link_data;
  logic [6:0] gap_thresh;
  logic       cfg_data_wr, cfg_prov, cfg_sel_wr, cfg_rwb;
  logic [6:0] cfg_chan;
  logic [4:0] cfg_slot, cfg_link;
  logic       out_valid, out_first;
  logic [6:0] out_chan;
  logic [7:0] out_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  gclk_slot_demux #(.SYNC_STAGES(2), .LINK_ID(MY_LINK)) uut (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_data(link_data),
    .gap_thresh(gap_thresh), .cfg_data_wr(cfg_data_wr), .cfg_chan(cfg_chan),
    .cfg_prov(cfg_prov), .cfg_sel_wr(cfg_sel_wr), .cfg_slot(cfg_slot),
    .cfg_link(cfg_link), .cfg_rwb(cfg_rwb), .out_valid(out_valid),
    .out_chan(out_chan), .out_byte(out_byte), .out_first(out_first));

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string cur_req = "R3 R4";
  logic [15:0] exp_q[$];
  logic       m_prov[32];
  logic [6:0] m_chan[32];
  logic       st_prov;
  logic [6:0] st_chan;

  // Monitor: pops expected {first, chan, byte} in order
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: unexpected byte chan=%0d data=%02h, expected none",
                 cur_req, out_chan, out_byte);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({out_first, out_chan, out_byte} !== e) begin
          n_bad++;
          $display("FAIL %s: got first=%0b chan=%0d data=%02h, expected first=%0b chan=%0d data=%02h",
                   cur_req, out_first, out_chan, out_byte, e[15], e[14:8], e[7:0]);
        end
      end
    end
  end

  task automatic cfg_write(input logic prov, input logic [6:0] chan,
                           input logic [4:0] slot, input logic [4:0] lnk,
                           input logic rwb, input bit stage);
    if (stage) begin
      @(negedge clk);
      cfg_prov = prov; cfg_chan = chan; cfg_data_wr = 1'b1;
      @(negedge clk);
      cfg_data_wr = 1'b0;
      st_prov = prov; st_chan = chan;
    end
    @(negedge clk);
    cfg_slot = slot; cfg_link = lnk; cfg_rwb = rwb; cfg_sel_wr = 1'b1;
    @(negedge clk);
    cfg_sel_wr = 1'b0;
    if (!rwb && lnk == 5'(MY_LINK) && slot != 0) begin
      m_prov[slot] = st_prov;
      m_chan[slot] = st_chan;
    end
  endtask

  task automatic send_bit(input logic b, input int low);
    link_clk = 1'b0;
    link_data = b;
    repeat (low) @(negedge clk);
    link_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] payload(input int seed, input int s);
    return 8'((seed * 73 + s * 29 + (s << 3)) ^ (seed << 5));
  endfunction

  // Sends a frame starting with a marker; pushes expected items per the map
  task automatic send_frame(input int seed, input int gap_low, input int nslots,
                            input int stretch_slot, input int stretch_low);
    for (int s = 1; s <= nslots; s++) begin
      logic [7:0] v;
      v = payload(seed, s);
      for (int b = 7; b >= 0; b--) begin
        int low;
        low = 4;
        if (s == 1 && b == 7) low = gap_low;
        else if (s == stretch_slot && b == 7) low = stretch_low;
        if (b == 0 && m_prov[s]) exp_q.push_back({(s == 1), m_chan[s], v});
        send_bit(v[b], low);
      end
    end
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: %0d expected bytes missing, expected 0", cur_req, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    link_clk = 1'b0; link_data = 1'b0; gap_thresh = 7'd12;
    cfg_data_wr = 1'b0; cfg_prov = 1'b0; cfg_chan = '0;
    cfg_sel_wr = 1'b0; cfg_slot = '0; cfg_link = '0; cfg_rwb = 1'b0;
    st_prov = 1'b0; st_chan = '0;
    for (int i = 0; i < 32; i++) begin m_prov[i] = 1'b0; m_chan[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, no output
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (out_valid) seen++;
      end
      n_cmp++;
      if (seen != 0) begin
        n_bad++;
        $display("FAIL R1: %0d output strobes before alignment, expected 0", seen);
      end
    end

    // R8 R7 R5 R6: map programming
    cfg_write(1, 7'd5,   5'd1,  5'(MY_LINK), 0, 1);
    cfg_write(1, 7'd9,   5'd2,  5'(MY_LINK), 0, 1);
    cfg_write(1, 7'd9,   5'd5,  5'(MY_LINK), 0, 1);   // R7 shared channel
    cfg_write(1, 7'd127, 5'd31, 5'(MY_LINK), 0, 1);
    cfg_write(1, 7'd0,   5'd10, 5'(MY_LINK), 0, 1);
    cfg_write(0, 7'd0,   5'd10, 5'(MY_LINK), 0, 1);   // R5 unprovision again
    cfg_write(1, 7'd33,  5'd6,  5'(MY_LINK), 0, 1);
    cfg_write(1, 7'd33,  5'd7,  5'(MY_LINK), 0, 0);   // R8 staged word reused
    cfg_write(1, 7'd77,  5'd3,  5'(MY_LINK), 1, 1);   // R8 read: ignored
    cfg_write(1, 7'd78,  5'd4,  5'(MY_LINK + 1), 0, 1); // R8 other link: ignored
    cfg_write(1, 7'd79,  5'd0,  5'(MY_LINK), 0, 1);   // R6 slot 0: ignored
    cfg_write(1, 7'd64,  5'd20, 5'(MY_LINK), 0, 1);

    cur_req = "R2 R3 R4 R5 R7 R8";
    send_frame(1, 12, 31, 0, 4);
    cur_req = "R6 R3 R4";
    send_frame(2, 12, 31, 0, 4);
    for (int i = 0; i < 8; i++) send_bit(i[0], 4);    // slot 0 byte: dropped
    cur_req = "R10";
    send_frame(3, 12, 5, 0, 4);
    send_bit(1'b1, 4); send_bit(1'b0, 4); send_bit(1'b1, 4);
    cur_req = "R10 R4";
    send_frame(4, 12, 31, 0, 4);
    drain();

    // R2 threshold boundary: stretched bit equal to threshold is ordinary
    gap_thresh = 7'd15;
    cur_req = "R2";
    send_frame(5, 16, 31, 11, 12);
    send_frame(6, 16, 31, 20, 12);
    drain();

    gap_thresh = 7'd12;
    cur_req = "R9 R3 R4";
    send_frame(7, 12, 31, 0, 4);
    send_bit(1'b0, 12);
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule